// File: doc/BRIEF.md
# E1 Synchronization Status Message Receive Validator

This block sits behind an E1 framer that has already found frame and CRC4 multiframe alignment. On every received frame it is given the timeslot 0 byte together with the frame's position (0 to 15) inside the CRC4 multiframe. It picks one spare bit position, chosen at run time from Sa4 to Sa8, and collects that bit from the four odd-numbered frames of each eight-frame sub-multiframe. This builds one 4-bit quality code per sub-multiframe, first bit received being the most significant.

A code is only believed once three consecutive sub-multiframes deliver the same value. Only then are the quality output and the valid flag updated. A sticky interrupt flag tells the host when a new quality level has been accepted. When the framer reports loss of multiframe lock, the block drops the valid flag and forgets its history, but it keeps showing the last accepted code. Every 4-bit value is handled the same way: well-known levels (0000 unknown, 0010 primary reference, 0100 and 1000 supply units, 1011 equipment clock, 1111 do not use) and reserved values alike.

Top module: `e1_ssm_rx`

## Requirements
- R1: With `sa_sel` = 0,1,2,3,4 the message bit is taken from Sa4,Sa5,Sa6,Sa7,Sa8, which is `ts0_byte[4 - sa_sel]` (bit 7 of the byte is the first bit on the line); values 5 to 7 select Sa8 (`ts0_byte[0]`).
- R2: Only cycles with `frm_stb` high, `mf_lock` high and an odd `frm_idx` contribute a bit. Even frames and cycles without the strobe have no effect.
- R3: Within a sub-multiframe (`frm_idx[3]` constant), frames 1,3,5,7 (or 9,11,13,15) supply message bits 3,2,1,0 in that order. A bit from a later position is used only if all earlier positions of the same sub-multiframe were taken in order. Otherwise the partial code is discarded until the next first-position frame.
- R4: When the third consecutive equal code completes, in that same clock edge `ssm_code` takes the code and `ssm_valid` goes high; further equal codes keep it unchanged.
- R5: A completed code that differs from the previous completed code restarts the match count at one; `ssm_code` and `ssm_valid` hold until the new code has been seen three times in a row.
- R6: `ssm_irq` is set on the edge where a code is accepted while `ssm_valid` is low or the accepted code differs from `ssm_code`. It stays set until a cycle with `irq_clr` high, and a set in the same cycle as a clear leaves it set.
- R7: Any cycle with `mf_lock` low clears `ssm_valid` on the next edge, discards the partial code and the match history, and leaves `ssm_code` unchanged.
- R8: Reserved codes (for example 0101) are validated and reported exactly like defined quality levels.
- R9: After reset `ssm_code` is 0000 and `ssm_valid` and `ssm_irq` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frm_stb | input | 1 | One-cycle strobe per received frame |
| ts0_byte | input | 8 | Timeslot 0 byte, bit 7 first on line |
| frm_idx | input | 4 | Frame position 0..15 in the CRC4 multiframe |
| mf_lock | input | 1 | Multiframe alignment is held |
| sa_sel | input | 3 | Spare bit carrying the message, 0 = Sa4 .. 4 = Sa8 |
| irq_clr | input | 1 | Clears the change interrupt |
| ssm_code | output | 4 | Last accepted quality code |
| ssm_valid | output | 1 | Code is currently confirmed |
| ssm_irq | output | 1 | Sticky change interrupt |

## Verification
On every cycle the assertions confirm these properties: lock loss clears the valid flag; a rising valid flag or a change of the confirmed code is always accompanied by the interrupt; the interrupt only falls after a clear; and the output code never moves without a locked frame strobe on the previous edge. Several behaviours need a reference model driven through the bench's scenarios: which Sa bit is picked, the bit order within a sub-multiframe, the three-in-a-row rule with its restart on mismatch, the discard of partial codes on skipped frames, and set-over-clear priority.

// File: rtl/e1_ssm_rx.sv
module e1_ssm_rx #(
  parameter int MATCH_N = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frm_stb,
  input  logic [7:0] ts0_byte,
  input  logic [3:0] frm_idx,
  input  logic       mf_lock,
  input  logic [2:0] sa_sel,
  input  logic       irq_clr,
  output logic [3:0] ssm_code,
  output logic       ssm_valid,
  output logic       ssm_irq
);
  localparam int MSG_W = 4;
  localparam int CNT_W = $clog2(MATCH_N + 1);

  logic [MSG_W-2:0] asm_q;
  logic [1:0]       nxt_q;
  logic             inprog_q;
  logic             half_q;
  logic [MSG_W-1:0] last_q;
  logic [CNT_W-1:0] mcnt_q;

  wire [2:0] sel_c  = (sa_sel > 3'd4) ? 3'd4 : sa_sel;
  wire [2:0] bitpos = 3'd4 - sel_c;
  wire       sa_bit = ts0_byte[bitpos];
  wire [1:0] pos    = frm_idx[2:1];
  wire       take   = frm_stb && mf_lock && frm_idx[0];
  wire       accept = take && ((pos == 2'd0) ||
                               (inprog_q && pos == nxt_q && frm_idx[3] == half_q));
  wire       done   = accept && (pos == 2'd3);

  wire [MSG_W-1:0] newc = {asm_q, sa_bit};
  wire             same = (mcnt_q != '0) && (newc == last_q);
  wire [CNT_W-1:0] mnext = !same ? CNT_W'(1) :
                           (mcnt_q == CNT_W'(MATCH_N)) ? mcnt_q : mcnt_q + CNT_W'(1);
  wire             hit  = done && (mnext == CNT_W'(MATCH_N));
  wire             ev   = hit && (!ssm_valid || newc != ssm_code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asm_q     <= '0;
      nxt_q     <= '0;
      inprog_q  <= 1'b0;
      half_q    <= 1'b0;
      last_q    <= '0;
      mcnt_q    <= '0;
      ssm_code  <= '0;
      ssm_valid <= 1'b0;
    end else if (!mf_lock) begin
      inprog_q  <= 1'b0;
      mcnt_q    <= '0;
      ssm_valid <= 1'b0;
    end else if (take) begin
      if (accept) begin
        asm_q    <= newc[MSG_W-2:0];
        nxt_q    <= pos + 2'd1;
        inprog_q <= !done;
        if (pos == 2'd0) half_q <= frm_idx[3];
      end else begin
        inprog_q <= 1'b0;
      end
      if (done) begin
        last_q <= newc;
        mcnt_q <= mnext;
      end
      if (hit) begin
        ssm_valid <= 1'b1;
        ssm_code  <= newc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ssm_irq <= 1'b0;
    else if (ev)      ssm_irq <= 1'b1;
    else if (irq_clr) ssm_irq <= 1'b0;
  end
endmodule

// File: rtl/e1_ssm_rx_chk.sv
module e1_ssm_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frm_stb,
  input logic       mf_lock,
  input logic       irq_clr,
  input logic [3:0] ssm_code,
  input logic       ssm_valid,
  input logic       ssm_irq
);
  assert_lock_loss_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mf_lock |=> !ssm_valid);

  assert_valid_rise_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ssm_valid) |-> ssm_irq);

  assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ssm_irq) |-> $past(irq_clr));

  assert_code_change_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ssm_valid && $past(ssm_valid) && ssm_code != $past(ssm_code)) |-> ssm_irq);

  assert_code_needs_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ssm_code != $past(ssm_code)) |-> ($past(frm_stb) && $past(mf_lock)));

  assert_valid_needs_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ssm_valid) |-> ($past(frm_stb) && $past(mf_lock)));
endmodule

bind e1_ssm_rx e1_ssm_rx_chk u_chk (.*);

// File: tb/sim_e1_ssm_rx.sv
module sim_e1_ssm_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frm_stb = 1'b0;
  logic [7:0] ts0_byte = '0;
  logic [3:0] frm_idx = '0;
  logic       mf_lock = 1'b0;
  logic [2:0] sa_sel = '0;
  logic       irq_clr = 1'b0;
  logic [3:0] ssm_code;
  logic       ssm_valid;
  logic       ssm_irq;

  always #10 clk = ~clk;

  e1_ssm_rx u0 (.*);

  int vectors = 0, miscompares = 0;
  string phase = "R9";
  bit started = 0, finished = 0;

  // reference model
  int m_code = 0, m_valid = 0, m_irq = 0;
  int m_nb = 0, m_half = 0, m_val = 0;
  int hist[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_code = 0; m_valid = 0; m_irq = 0; m_nb = 0; hist.delete();
    end else begin
      int ev;
      ev = 0;
      if (!mf_lock) begin
        m_nb = 0; m_valid = 0; hist.delete();
      end else if (frm_stb && frm_idx[0]) begin
        int s, b, p, h;
        s = (sa_sel > 4) ? 4 : int'(sa_sel);
        b = int'(ts0_byte[4 - s]);
        p = int'(frm_idx[2:1]);
        h = int'(frm_idx[3]);
        if (p == 0) begin
          m_val = b; m_nb = 1; m_half = h;
        end else if (m_nb == p && h == m_half) begin
          m_val = m_val * 2 + b; m_nb++;
        end else m_nb = 0;
        if (m_nb == 4) begin
          m_nb = 0;
          hist.push_back(m_val);
          if (hist.size() > 3) void'(hist.pop_front());
          if (hist.size() == 3 && hist[0] == hist[1] && hist[1] == hist[2]) begin
            if (!m_valid || m_code != m_val) ev = 1;
            m_valid = 1; m_code = m_val;
          end
        end
      end
      if (ev) m_irq = 1;
      else if (irq_clr) m_irq = 0;
      started = 1;
    end
  end

  always @(negedge clk) begin
    if (started && !finished) begin
      vectors++;
      if (int'(ssm_code) != m_code) begin
        miscompares++;
        $display("FAIL %s ssm_code act=%h exp=%h t=%0t", phase, ssm_code, m_code, $time);
      end
      if (int'(ssm_valid) != m_valid) begin
        miscompares++;
        $display("FAIL %s ssm_valid act=%0d exp=%0d t=%0t", phase, ssm_valid, m_valid, $time);
      end
      if (int'(ssm_irq) != m_irq) begin
        miscompares++;
        $display("FAIL %s ssm_irq act=%0d exp=%0d t=%0t", phase, ssm_irq, m_irq, $time);
      end
    end
  end

  task automatic send_frame(input int idx, input logic [7:0] b);
    @(negedge clk);
    frm_stb = 1'b1; frm_idx = 4'(idx); ts0_byte = b;
    @(negedge clk);
    frm_stb = 1'b0; ts0_byte = 8'($urandom);
  endtask

  function automatic logic [7:0] make_byte(input int f, input logic [3:0] code, input int sel);
    logic [7:0] b;
    int s;
    b = 8'($urandom);
    s = (sel > 4) ? 4 : sel;
    if (f % 2 == 1) b[4 - s] = code[3 - (f >> 1)];
    return b;
  endfunction

  task automatic send_smf(input int h, input logic [3:0] code);
    for (int f = 0; f < 8; f++) send_frame(h * 8 + f, make_byte(f, code, int'(sa_sel)));
  endtask

  task automatic send_codes(input logic [3:0] code, input int n);
    for (int i = 0; i < n; i++) send_smf(i % 2, code);
  endtask

  initial begin
    #2000000;
    miscompares++;
    $display("FAIL watchdog expired in %s", phase);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    phase = "R9";
    repeat (4) @(negedge clk);

    mf_lock = 1'b1;
    phase = "R4";
    send_codes(4'b0010, 4);
    repeat (3) @(negedge clk);

    phase = "R6";
    @(negedge clk) irq_clr = 1'b1;
    @(negedge clk) irq_clr = 1'b0;
    send_codes(4'b0010, 2);
    irq_clr = 1'b1;
    send_codes(4'b1011, 3);
    irq_clr = 1'b0;
    repeat (2) @(negedge clk);
    @(negedge clk) irq_clr = 1'b1;
    @(negedge clk) irq_clr = 1'b0;

    phase = "R5";
    send_codes(4'b1000, 2);
    send_smf(0, 4'b0100);
    send_codes(4'b1000, 2);
    send_codes(4'b1000, 3);
    @(negedge clk) irq_clr = 1'b1;
    @(negedge clk) irq_clr = 1'b0;

    phase = "R1";
    sa_sel = 3'd2;
    send_codes(4'b0100, 3);
    sa_sel = 3'd4;
    send_codes(4'b1100, 3);
    sa_sel = 3'd7;
    send_codes(4'b1111, 3);
    sa_sel = 3'd1;
    send_codes(4'b0000, 3);

    phase = "R2";
    sa_sel = 3'd0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      frm_idx = 4'(2 * i + 1); ts0_byte = 8'($urandom);
    end
    for (int i = 0; i < 8; i++) send_frame(2 * i, 8'($urandom));
    send_codes(4'b0010, 3);

    phase = "R3";
    send_frame(1, make_byte(1, 4'b1000, 0));
    send_frame(3, make_byte(3, 4'b1000, 0));
    send_frame(7, make_byte(7, 4'b1000, 0));
    send_frame(9, make_byte(1, 4'b1000, 0));
    send_frame(11, make_byte(3, 4'b1000, 0));
    send_frame(5, make_byte(5, 4'b1000, 0));
    send_frame(15, make_byte(7, 4'b1000, 0));
    send_codes(4'b1000, 3);

    phase = "R7";
    send_codes(4'b0100, 2);
    for (int f = 0; f < 5; f++) send_frame(f, make_byte(f, 4'b0100, 0));
    @(negedge clk) mf_lock = 1'b0;
    send_frame(5, make_byte(5, 4'b0100, 0));
    @(negedge clk) mf_lock = 1'b1;
    send_frame(7, make_byte(7, 4'b0100, 0));
    send_codes(4'b0100, 2);
    send_codes(4'b0100, 1);

    phase = "R8";
    @(negedge clk) irq_clr = 1'b1;
    @(negedge clk) irq_clr = 1'b0;
    send_codes(4'b0101, 3);
    send_codes(4'b0101, 2);
    repeat (4) @(negedge clk);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule